// File: doc/BRIEF.md
# E1 CAS Multiframe Aligner and Signalling Extractor

This block sits behind a basic-frame aligner on an E1 receive path. Once per basic frame it takes the timeslot 16 byte, marked by a one-cycle valid strobe. From that stream it locates the 16-frame channel-associated-signalling multiframe. It keeps a frame number that counts 0 to 15. It sorts the ABCD signalling nibbles of the 30 payload channels into a register file that is read as a flat vector.

The signalling multiframe is tracked on its own. It does not depend on any CRC-4 multiframe, and its boundary may fall anywhere relative to one. The block starts hunting for the alignment pattern: an all-zero upper nibble in timeslot 16, preceded by a timeslot 16 byte that was not all zeros. The pattern must come back exactly 16 frames later before the block declares lock. It stays locked through isolated errors. It drops lock after repeated pattern errors or after a long run of all-zero timeslot 16 bytes.

While locked, the block reports the far end's multiframe alarm bit and the spare bits. It also drives the local transmit alarm bit, which is asserted whenever the local side is not aligned.

Top module: `cas_mf_aligner`

## Requirements
- R1: After reset, `aligned`=0, `tx_y`=1, `frame_num`=0, every ABCD nibble is 0, `sig_chg`=0, `rx_y`=0 and `rx_x`=3'b111.
- R2: While hunting, a valid byte with bits [7:4]=0000 whose previous valid byte was nonzero sets `frame_num` to 0 on the next clock. Every other valid byte advances `frame_num` by one, wrapping from 15 to 0.
- R3: After a detection, the byte that arrives 16 frames later (frame 0) with bits [7:4]=0000 sets `aligned`=1. If that byte has any other upper nibble, the block returns to hunting.
- R4: While aligned, one frame-0 byte with a nonzero upper nibble leaves `aligned` at 1. Two consecutive errored frame-0 bytes clear `aligned`.
- R5: While confirming or aligned, the 16th consecutive all-zero valid byte returns the block to hunting (`aligned`=0).
- R6: `tx_y` is 0 exactly while `aligned` is 1.
- R7: While aligned, the byte of frame n (1..15) writes bits [7:4] to channel n and bits [3:0] to channel n+15. Channel k occupies `abcd[4k-1:4k-4]`.
- R8: ABCD nibbles hold their values while the block is not aligned.
- R9: `sig_chg` pulses high for one cycle, together with the nibble update, when a write changes any channel's value.
- R10: On a frame-0 byte with a good pattern while confirming or aligned, `rx_y` takes bit 2 and `rx_x` takes {bit 3, bit 1, bit 0}.
- R11: Cycles with `ts16_vld`=0 change no state or output, and `sig_chg` is 0 in them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts16_vld | input | 1 | Timeslot 16 byte strobe, one per basic frame |
| ts16_byte | input | 8 | Timeslot 16 byte, bit 7 sent first |
| aligned | output | 1 | Multiframe alignment held |
| frame_num | output | 4 | Number of the most recent frame |
| abcd | output | 120 | ABCD nibbles, channel k at bits 4k-1..4k-4 |
| sig_chg | output | 1 | One-cycle pulse when any nibble changes |
| rx_y | output | 1 | Received remote multiframe alarm bit |
| rx_x | output | 3 | Received spare bits |
| tx_y | output | 1 | Transmit multiframe alarm bit |

## Verification
The hardest state to reach from the ports is a loss of lock caused by error counting that has to span two multiframes. The bench first locks on clean multiframes. It then sends one errored frame 0 followed by a clean one, to show that the error count clears. After that it sends two errored frame 0s in a row. The zero-run loss is reached by sending sixteen all-zero bytes while locked. A long random phase follows, with gaps in the valid strobe and frequent zero nibbles. That phase leads the hunter into false detections and failed confirmations.

// File: rtl/cas_mf_aligner.sv
module cas_mf_aligner #(
  parameter int ERR_LIMIT  = 2,
  parameter int ZERO_LIMIT = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ts16_vld,
  input  logic [7:0]   ts16_byte,
  output logic         aligned,
  output logic [3:0]   frame_num,
  output logic [119:0] abcd,
  output logic         sig_chg,
  output logic         rx_y,
  output logic [2:0]   rx_x,
  output logic         tx_y
);
  localparam int HALF = 15;
  localparam int NCH  = 2 * HALF;
  localparam int ZW   = $clog2(ZERO_LIMIT + 1);
  localparam int EW   = $clog2(ERR_LIMIT + 1);

  typedef enum logic [1:0] {HUNT, CONF, LOCK} st_t;
  st_t st;

  logic          prev_nz;
  logic [ZW-1:0] zcnt;
  logic [EW-1:0] ecnt;
  logic [3:0]    ch [NCH];

  wire [3:0] fn_in     = frame_num + 4'd1;
  wire       at_f0     = (fn_in == 4'd0);
  wire       mfas_ok   = (ts16_byte[7:4] == 4'h0);
  wire       all_zero  = (ts16_byte == 8'h00);
  wire       zero_loss = all_zero && (zcnt >= ZW'(ZERO_LIMIT - 1));
  wire       detect    = (st == HUNT) && mfas_ok && prev_nz;
  wire       upd       = (st == LOCK) && !at_f0;
  wire [4:0] hi_i      = {1'b0, fn_in} - 5'd1;
  wire [4:0] lo_i      = hi_i + 5'd15;
  wire       diff      = (ch[hi_i] != ts16_byte[7:4]) || (ch[lo_i] != ts16_byte[3:0]);

  assign aligned = (st == LOCK);
  assign tx_y    = ~aligned;

  for (genvar k = 0; k < NCH; k++) begin : g_flat
    assign abcd[4*k +: 4] = ch[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= HUNT;
      prev_nz   <= 1'b0;
      zcnt      <= '0;
      ecnt      <= '0;
      frame_num <= 4'd0;
      sig_chg   <= 1'b0;
      rx_y      <= 1'b0;
      rx_x      <= 3'b111;
      for (int k = 0; k < NCH; k++) ch[k] <= 4'h0;
    end else begin
      sig_chg <= 1'b0;
      if (ts16_vld) begin
        prev_nz   <= !all_zero;
        zcnt      <= !all_zero ? '0 : (zcnt == ZW'(ZERO_LIMIT) ? zcnt : zcnt + 1'b1);
        frame_num <= detect ? 4'd0 : fn_in;
        if (upd) begin
          ch[hi_i] <= ts16_byte[7:4];
          ch[lo_i] <= ts16_byte[3:0];
          sig_chg  <= diff;
        end
        if (st != HUNT && at_f0 && mfas_ok) begin
          rx_y <= ts16_byte[2];
          rx_x <= {ts16_byte[3], ts16_byte[1], ts16_byte[0]};
        end
        if (st != HUNT && zero_loss) begin
          st   <= HUNT;
          ecnt <= '0;
        end else begin
          unique case (st)
            HUNT: if (detect) st <= CONF;
            CONF: begin
              ecnt <= '0;
              if (at_f0) st <= mfas_ok ? LOCK : HUNT;
            end
            LOCK: if (at_f0) begin
              if (mfas_ok) ecnt <= '0;
              else if (ecnt == EW'(ERR_LIMIT - 1)) begin
                st   <= HUNT;
                ecnt <= '0;
              end else ecnt <= ecnt + 1'b1;
            end
            default: st <= HUNT;
          endcase
        end
      end
    end
  end
endmodule

module cas_mf_aligner_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         ts16_vld,
  input logic         aligned,
  input logic [3:0]   frame_num,
  input logic [119:0] abcd,
  input logic         sig_chg
);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ts16_vld |=> ($stable(frame_num) && $stable(aligned) && $stable(abcd) && !sig_chg));
  // R3
  lock_at_f0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned) |-> (frame_num == 4'd0));
  // R8
  hold_unaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned |=> $stable(abcd));
  // R9
  chg_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sig_chg |-> (abcd != $past(abcd)));
  // R2
  fn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ts16_vld && aligned) |=> (frame_num == $past(frame_num) + 4'd1 || !aligned));
endmodule

bind cas_mf_aligner cas_mf_aligner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ts16_vld(ts16_vld), .aligned(aligned),
  .frame_num(frame_num), .abcd(abcd), .sig_chg(sig_chg));

// File: tb/cas_mf_aligner_tb.sv
module cas_mf_aligner_tb_top;
  logic clk = 0, rst_n = 0, vld = 0;
  logic [7:0] byt = 0;
  logic aligned, sig_chg, rx_y, tx_y;
  logic [3:0] frame_num;
  logic [119:0] abcd;
  logic [2:0] rx_x;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  cas_mf_aligner dut_i (.clk(clk), .rst_n(rst_n), .ts16_vld(vld), .ts16_byte(byt),
    .aligned(aligned), .frame_num(frame_num), .abcd(abcd), .sig_chg(sig_chg),
    .rx_y(rx_y), .rx_x(rx_x), .tx_y(tx_y));

  int m_st, m_fn, m_prevnz, m_z, m_err, m_chg, m_y, m_x;
  int m_ch [1:30];
  int cv [1:30];

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [119:0] exp_abcd();
    logic [119:0] v;
    for (int k = 1; k <= 30; k++) v[4*(k-1) +: 4] = m_ch[k][3:0];
    return v;
  endfunction

  task automatic cmp_all();
    logic [119:0] e;
    e = exp_abcd();
    chk("R3 aligned", aligned, m_st == 2);
    chk("R6 tx_y", tx_y, m_st != 2);
    chk("R2 frame_num", frame_num, m_fn);
    chk("R9 sig_chg", sig_chg, m_chg);
    chk("R10 rx_y", rx_y, m_y);
    chk("R10 rx_x", rx_x, m_x);
    checks++;
    if (abcd !== e) begin
      errors++;
      $display("FAIL R7 abcd actual=%h expected=%h", abcd, e);
    end
  endtask

  task automatic model(input logic v, input logic [7:0] b);
    int fi, zl, ok, az, det, ns;
    m_chg = 0;
    if (!v) return;
    fi = (m_fn + 1) % 16;
    ok = (b[7:4] == 0);
    az = (b == 0);
    zl = az && (m_z >= 15);
    det = (m_st == 0) && ok && m_prevnz;
    if (m_st == 2 && fi != 0) begin
      if (m_ch[fi] != b[7:4] || m_ch[fi+15] != b[3:0]) m_chg = 1;
      m_ch[fi] = b[7:4];
      m_ch[fi+15] = b[3:0];
    end
    if (m_st != 0 && fi == 0 && ok) begin
      m_y = b[2];
      m_x = {b[3], b[1], b[0]};
    end
    ns = m_st;
    if (m_st != 0 && zl) begin ns = 0; m_err = 0; end
    else if (m_st == 0) begin if (det) ns = 1; end
    else if (m_st == 1) begin m_err = 0; if (fi == 0) ns = ok ? 2 : 0; end
    else if (fi == 0) begin
      if (ok) m_err = 0;
      else if (m_err == 1) begin ns = 0; m_err = 0; end
      else m_err = m_err + 1;
    end
    m_st = ns;
    m_prevnz = !az;
    m_z = az ? ((m_z < 16) ? m_z + 1 : 16) : 0;
    m_fn = det ? 0 : fi;
  endtask

  task automatic send(input logic v, input logic [7:0] b);
    @(negedge clk);
    cmp_all();
    vld = v;
    byt = b;
    model(v, b);
  endtask

  task automatic send_mf(input logic [7:0] f0);
    for (int f = 0; f < 16; f++)
      send(1'b1, f == 0 ? f0 : {cv[f][3:0], cv[f+15][3:0]});
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int fn_save;
    logic [119:0] snap;
    m_st = 0; m_fn = 0; m_prevnz = 0; m_z = 0; m_err = 0; m_chg = 0; m_y = 0; m_x = 7;
    for (int k = 1; k <= 30; k++) begin m_ch[k] = 0; cv[k] = (k % 7) + 1 + ((k % 3) << 3); end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    chk("R1 aligned", aligned, 0);
    chk("R1 tx_y", tx_y, 1);
    chk("R1 abcd", abcd == 0, 1);
    chk("R1 rx_x", rx_x, 7);
    repeat (5) send(1, 8'h55);
    send_mf(8'h0B); send_mf(8'h0B); send_mf(8'h0B);
    send(0, 0);
    chk("R3 locked", aligned, 1);
    chk("R7 ch1", abcd[3:0], cv[1]);
    chk("R7 ch16", abcd[63:60], cv[16]);
    // R11 gaps
    fn_save = frame_num;
    repeat (4) send(0, 8'hFF);
    chk("R11 fn hold", frame_num, fn_save);
    // R9 change
    cv[5] = 9; cv[22] = 4;
    send_mf(8'h0B);
    send(0, 0);
    chk("R9 ch5", abcd[19:16], 9);
    // R4 single error tolerated
    send_mf(8'h8B); send_mf(8'h0B);
    send(0, 0);
    chk("R4 single err", aligned, 1);
    send_mf(8'h8B); send_mf(8'h8B);
    send(0, 0);
    chk("R4 two errs", aligned, 0);
    // R8 hold while not aligned
    snap = abcd;
    cv[2] = 12; cv[20] = 3;
    send_mf(8'h06);
    send(0, 0);
    chk("R8 hold", abcd == snap, 1);
    send_mf(8'h06); send_mf(8'h06);
    send(0, 0);
    chk("R10 rx_y", rx_y, 1);
    chk("R10 rx_x", rx_x, 3'b010);
    chk("R7 ch2", abcd[7:4], 12);
    // R5 zero run
    repeat (16) send(1, 8'h00);
    send(0, 0);
    chk("R5 zero loss", aligned, 0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      if ((i % 5) == 0) r[7:4] = 0;
      if ((i % 37) == 0) r = 0;
      send(($urandom % 8) != 0, r);
    end
    for (int j = 0; j < 40; j++) send_mf(8'h0B);
    send(0, 0);
    chk("R3 relock", aligned, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule